// File: doc/BRIEF.md
# Serial Audio Stereo Word Receiver

This block takes the three-wire stereo audio link (serial bit clock, word-select line and a single data line) and turns it into parallel PCM words. It lives entirely on the serial bit clock: every rising edge samples one data bit and one word-select level. Each completed channel word is placed in a 32-bit holding register along with a flag that says which channel it belongs to. A toggle output flips once per word, so logic in another clock domain can synchronize the toggle and pick up the held word.

Configuration inputs set the word length, the bit order (most significant bit first or least significant bit first) and the alignment of the word-select edge against the first data bit. They also choose whether a short word is sign-extended or left-justified in the 32-bit result. After enable is raised, the receiver ignores the link until a left-channel word starts from its first bit. It then captures continuously, so a partial sample never reaches the output. If word select switches before a word has all of its bits, that word is dropped and a sticky error flag is raised.

Top module: `aud_ser_rx`

## Requirements
- R1: Data and word select are sampled on the rising edge of `sclk_i`. In the default order the first bit of a word is its most significant bit. On the rising edge that samples the last configured bit, `word_o` and `word_right_o` are loaded and `word_tog_o` inverts, and all three are visible after that edge.
- R2: Word select low means left and high means right, and `word_right_o` carries the level of the captured word. With `cfg_nodelay_i` = 0, the first bit of a word is the one sampled on the rising edge after the first edge that samples the new word-select level.
- R3: With `cfg_nodelay_i` = 1, the first bit of a word is the one sampled on the same edge that first samples the new word-select level. Any combination of alignment and bit order works.
- R4: With `cfg_lsb_first_i` = 1, the first bit of a word is its least significant bit.
- R5: The effective word length is `cfg_len_i` limited to the range 12 to 32: values below 12 act as 12 and values above 32 act as 32. Bits that arrive in a channel slot after the word is complete are ignored.
- R6: With `cfg_left_just_i` = 0, a word of length N goes to `word_o` sign-extended from bit N-1. With `cfg_left_just_i` = 1, it goes to `word_o[31:32-N]` and the lower bits are zero.
- R7: While `en_i` is low, no word completes. After `en_i` rises, a word is captured only from the next left word whose first bit arrives with the receiver enabled. Lowering `en_i` abandons any word in progress.
- R8: While capturing, if word select changes before the effective number of bits of a word has arrived, that word is not output and `frame_err_o` goes high. It stays high until reset. The word that starts at that change is captured normally.
- R9: While `rst_ni` is low, `word_o`, `word_right_o`, `word_tog_o` and `frame_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial bit clock; rising edge samples the link |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wsel_i | input | 1 | Word select: 0 = left, 1 = right |
| sdata_i | input | 1 | Serial data bit |
| en_i | input | 1 | Capture enable |
| cfg_len_i | input | 6 | Word length in bits, limited to 12..32 |
| cfg_lsb_first_i | input | 1 | 1 = least significant bit arrives first |
| cfg_nodelay_i | input | 1 | 1 = first bit coincides with word-select change |
| cfg_left_just_i | input | 1 | 1 = left-justify, 0 = sign-extend |
| word_o | output | 32 | Last completed word |
| word_right_o | output | 1 | Channel of `word_o`: 1 = right |
| word_tog_o | output | 1 | Inverts once per completed word |
| frame_err_o | output | 1 | Sticky short-word error |

## Verification
A bit counter that is one step out of line shows up at the ports within the same word. Every value captured after it is shifted by one bit, and the toggle flips one edge early or late. A bad alignment choice or a wrong channel start appears as a wrong `word_right_o` flag on the first captured word, or as an extra toggle while the receiver should still be waiting. Errors in the enable and framing logic show up as a toggle on a word that should be discarded, or as `frame_err_o` staying low one slot after a short word. So every fault becomes visible within one frame of stimulus.

// File: rtl/aud_ser_rx_pkg.sv
package aud_ser_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/aud_ser_rx_align.sv
module aud_ser_rx_align (
    input  logic sclk_i,
    input  logic rst_ni,
    input  logic wsel_i,
    input  logic nodelay_i,
    output logic chan_o,
    output logic chg_o
);
    typedef struct packed {
        logic       ws1;
        logic       ws2;
        logic [1:0] fill;
    } align_s;

    align_s s_d, s_q;
    logic   prev_lvl;

    always_comb begin
        s_d      = s_q;
        s_d.ws1  = wsel_i;
        s_d.ws2  = s_q.ws1;
        s_d.fill = (s_q.fill == 2'd2) ? 2'd2 : s_q.fill + 2'd1;
        // Channel level of the bit on the data line this edge
        chan_o   = nodelay_i ? wsel_i  : s_q.ws1;
        prev_lvl = nodelay_i ? s_q.ws1 : s_q.ws2;
        chg_o    = (s_q.fill == 2'd2) && (chan_o != prev_lvl);
    end

    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end
endmodule

// File: rtl/aud_ser_rx_deser.sv
module aud_ser_rx_deser
    import aud_ser_rx_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              sclk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              chan_i,
    input  logic              chg_i,
    input  logic              sdata_i,
    input  logic              lsb_first_i,
    input  logic [CNT_W-1:0]  len_i,
    output logic              fin_o,
    output logic [WORD_W-1:0] fin_raw_o,
    output logic              fin_right_o,
    output logic              ferr_o
);
    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shr;
        logic              right;
        logic              ferr;
    } deser_s;

    deser_s s_d, s_q;

    function automatic logic [WORD_W-1:0] push_bit(input logic [WORD_W-1:0] cur,
                                                   input logic b, input logic lsb);
        return lsb ? {b, cur[WORD_W-1:1]} : {cur[WORD_W-2:0], b};
    endfunction

    always_comb begin
        s_d   = s_q;
        fin_o = 1'b0;
        if (!en_i) begin
            s_d.st = ST_IDLE;
        end else begin
            unique case (s_q.st)
                ST_IDLE: s_d.st = ST_WAIT;
                ST_WAIT: begin
                    if (chg_i && !chan_i) begin
                        s_d.st    = ST_RUN;
                        s_d.cnt   = CNT_W'(1);
                        s_d.shr   = push_bit('0, sdata_i, lsb_first_i);
                        s_d.right = 1'b0;
                    end
                end
                ST_RUN: begin
                    if (chg_i) begin
                        if (s_q.cnt < len_i) s_d.ferr = 1'b1;
                        s_d.cnt   = CNT_W'(1);
                        s_d.shr   = push_bit('0, sdata_i, lsb_first_i);
                        s_d.right = chan_i;
                    end else if (s_q.cnt < len_i) begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                        s_d.shr = push_bit(s_q.shr, sdata_i, lsb_first_i);
                        fin_o   = (s_d.cnt == len_i);
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
        fin_raw_o   = s_d.shr;
        fin_right_o = s_d.right;
        ferr_o      = s_q.ferr;
    end

    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: ST_IDLE, default: '0};
        else         s_q <= s_d;
    end

    // R7: nothing completes while capture is disabled
    p_quiet_off_r7: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        !en_i |-> !fin_o);
    // R5: a word never completes on a channel change (length is at least 12)
    p_fin_not_on_chg_r5: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        fin_o |-> !chg_i);
    // R7: in the waiting state no word is produced
    p_wait_silent_r7: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        (s_q.st == ST_WAIT) |-> !fin_o);
endmodule

// File: rtl/aud_ser_rx_format.sv
module aud_ser_rx_format #(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] raw_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic              lsb_first_i,
    input  logic              left_just_i,
    output logic [WORD_W-1:0] word_o
);
    logic [CNT_W-1:0]         pad;
    logic [WORD_W-1:0]        just;
    logic signed [WORD_W-1:0] ext;

    always_comb begin
        pad  = CNT_W'(WORD_W) - len_i;
        // LSB-first words already sit at the top of the register
        just = lsb_first_i ? raw_i : (raw_i << pad);
    end

    assign ext = $signed(just) >>> pad;

    always_comb begin
        word_o = left_just_i ? just : ext;
    end
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx #(
    parameter int WORD_W  = 32,
    parameter int MIN_LEN = 12,
    localparam int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              sclk_i,
    input  logic              rst_ni,
    input  logic              wsel_i,
    input  logic              sdata_i,
    input  logic              en_i,
    input  logic [CNT_W-1:0]  cfg_len_i,
    input  logic              cfg_lsb_first_i,
    input  logic              cfg_nodelay_i,
    input  logic              cfg_left_just_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_right_o,
    output logic              word_tog_o,
    output logic              frame_err_o
);
    localparam logic [CNT_W-1:0] LEN_LO = CNT_W'(MIN_LEN);
    localparam logic [CNT_W-1:0] LEN_HI = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              right;
        logic              tog;
    } hold_s;

    hold_s             s_d, s_q;
    logic [CNT_W-1:0]  eff_len;
    logic              chan, chg, fin, fin_right;
    logic [WORD_W-1:0] fin_raw, fin_word;

    always_comb begin
        if (cfg_len_i < LEN_LO)      eff_len = LEN_LO;
        else if (cfg_len_i > LEN_HI) eff_len = LEN_HI;
        else                         eff_len = cfg_len_i;
    end

    aud_ser_rx_align u_align (
        .sclk_i    (sclk_i),
        .rst_ni    (rst_ni),
        .wsel_i    (wsel_i),
        .nodelay_i (cfg_nodelay_i),
        .chan_o    (chan),
        .chg_o     (chg)
    );

    aud_ser_rx_deser #(.WORD_W(WORD_W)) u_deser (
        .sclk_i      (sclk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .chan_i      (chan),
        .chg_i       (chg),
        .sdata_i     (sdata_i),
        .lsb_first_i (cfg_lsb_first_i),
        .len_i       (eff_len),
        .fin_o       (fin),
        .fin_raw_o   (fin_raw),
        .fin_right_o (fin_right),
        .ferr_o      (frame_err_o)
    );

    aud_ser_rx_format #(.WORD_W(WORD_W)) u_format (
        .raw_i       (fin_raw),
        .len_i       (eff_len),
        .lsb_first_i (cfg_lsb_first_i),
        .left_just_i (cfg_left_just_i),
        .word_o      (fin_word)
    );

    always_comb begin
        s_d = s_q;
        if (fin) begin
            s_d.word  = fin_word;
            s_d.right = fin_right;
            s_d.tog   = ~s_q.tog;
        end
    end

    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign word_o       = s_q.word;
    assign word_right_o = s_q.right;
    assign word_tog_o   = s_q.tog;

    // R8: the error flag never clears without reset
    p_ferr_sticky_r8: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        frame_err_o |=> frame_err_o);
    // R7: a new word only appears after an edge with capture enabled
    p_tog_needs_en_r7: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        $changed(word_tog_o) |-> $past(en_i));
    // R6: sign-extended output has identical bits from N-1 upward
    p_sign_ext_r6: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        ($changed(word_tog_o) && !$past(cfg_left_just_i)) |->
        (((word_o ^ {WORD_W{word_o[WORD_W-1]}}) >> ($past(eff_len) - CNT_W'(1))) == '0));
    // R6: left-justified output has zero padding below the word
    p_left_pad_r6: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        ($changed(word_tog_o) && $past(cfg_left_just_i)) |->
        ((word_o << $past(eff_len)) == '0));
endmodule

// File: tb/aud_ser_rx_tb.sv
module aud_ser_rx_tb;
    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wsel = 1'b0, sdata = 1'b0, en = 1'b0;
    logic [5:0]  cfg_len = 6'd16;
    logic        cfg_lsb = 1'b0, cfg_nodelay = 1'b0, cfg_lj = 1'b0;
    logic [31:0] word;
    logic        word_right, word_tog, frame_err;

    int          n_chk = 0, n_fail = 0;
    int          eff_L = 16;
    string       cur_tag = "R1";
    logic [32:0] exp_q[$];
    logic        prev_tog = 1'b0;
    bit          done = 1'b0;

    always #5 sclk = ~sclk;

    aud_ser_rx u_dut (
        .sclk_i (sclk), .rst_ni (rst_n), .wsel_i (wsel), .sdata_i (sdata),
        .en_i (en), .cfg_len_i (cfg_len), .cfg_lsb_first_i (cfg_lsb),
        .cfg_nodelay_i (cfg_nodelay), .cfg_left_just_i (cfg_lj),
        .word_o (word), .word_right_o (word_right), .word_tog_o (word_tog),
        .frame_err_o (frame_err)
    );

    function automatic logic [31:0] fmt(input logic [31:0] v, input int L, input bit lj);
        logic [31:0] m;
        logic [31:0] x;
        m = (L >= 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 32'd1);
        x = v & m;
        if (lj)          return x << (32 - L);
        else if (x[L-1]) return x | ~m;
        else             return x;
    endfunction

    function automatic logic [31:0] pat(input int k, input int ch, input int L);
        logic [31:0] m;
        m = (L >= 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 32'd1);
        case (k)
            0: return 32'd1 << (L - 1);
            1: return m;
            2: return m >> 1;
            3: return 32'd0;
            default: return (32'(k) * 32'h9E37_79B1 + 32'(ch) * 32'h5BD1_E995) & m;
        endcase
    endfunction

    // Completion monitor: samples 1 ns after each rising edge
    always @(posedge sclk) begin
        #1;
        if (rst_n && (word_tog !== prev_tog)) begin
            logic [32:0] e;
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R7 unexpected word actual=%h expected=none", word);
            end else begin
                e = exp_q.pop_front();
                n_chk++;
                if (word !== e[31:0]) begin
                    n_fail++;
                    $display("FAIL %s word actual=%h expected=%h", cur_tag, word, e[31:0]);
                end
                n_chk++;
                if (word_right !== e[32]) begin
                    n_fail++;
                    $display("FAIL R2 channel flag actual=%b expected=%b", word_right, e[32]);
                end
            end
        end
        prev_tog = word_tog;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic send_slot(input bit ch, input logic [31:0] v, input int nbits,
                             input bit push, input int en_at);
        if (push && nbits >= eff_L) exp_q.push_back({ch, fmt(v, eff_L, cfg_lj)});
        for (int j = 0; j < nbits; j++) begin
            @(negedge sclk);
            if (j == en_at) en = 1'b1;
            wsel  = (!cfg_nodelay && j == nbits - 1) ? ~ch : ch;
            if (j < eff_L) sdata = cfg_lsb ? v[j] : v[eff_L - 1 - j];
            else           sdata = 1'b0;
        end
    endtask

    task automatic do_reset(input logic [5:0] len, input int L, input bit lsb,
                            input bit nod, input bit lj);
        @(negedge sclk);
        rst_n = 1'b0; en = 1'b0; wsel = 1'b0; sdata = 1'b0;
        cfg_len = len; eff_L = L; cfg_lsb = lsb; cfg_nodelay = nod; cfg_lj = lj;
        exp_q.delete();
        repeat (2) @(negedge sclk);
        // R9: reset values
        check(word === 32'd0 && word_right === 1'b0 && word_tog === 1'b0 && frame_err === 1'b0,
              "R9", "reset outputs", {word[31:3], word_right, word_tog, frame_err}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic run_cfg(input logic [5:0] len, input int L, input int S,
                           input bit lsb, input bit nod, input bit lj, input string tag);
        do_reset(len, L, lsb, nod, lj);
        cur_tag = tag;
        send_slot(1'b1, 32'h5A5A_5A5A, S, 1'b0, -1);
        // R7: enabled halfway through a left word: that word and the next right are dropped
        send_slot(1'b0, 32'hFFFF_0000, S, 1'b0, S / 2);
        send_slot(1'b1, 32'h1234_5678, S, 1'b0, -1);
        for (int k = 0; k < 6; k++) begin
            send_slot(1'b0, pat(k, 0, L), S, 1'b1, -1);
            send_slot(1'b1, pat(k, 1, L), S, 1'b1, -1);
        end
        @(negedge sclk);
        en = 1'b0;
        send_slot(1'b0, 32'h0F0F_0F0F, S, 1'b0, -1);
        repeat (2) @(negedge sclk);
        check(exp_q.size() == 0, "R7", "pending words after disable", 32'(exp_q.size()), 32'd0);
        check(frame_err === 1'b0, "R8", "spurious frame error", {31'd0, frame_err}, 32'd0);
    endtask

    initial begin
        int lens[5];
        lens = '{12, 16, 20, 24, 32};
        for (int lsb = 0; lsb < 2; lsb++)
            for (int nod = 0; nod < 2; nod++)
                for (int lj = 0; lj < 2; lj++)
                    for (int i = 0; i < 5; i++) begin
                        int L, S;
                        string tag;
                        L = lens[i];
                        S = (L == 12 || L == 32) ? L : L + 4;
                        if (lsb != 0)      tag = "R4";
                        else if (nod != 0) tag = "R3";
                        else if (lj != 0)  tag = "R6";
                        else if (S > L)    tag = "R5";
                        else               tag = "R1";
                        run_cfg(6'(L), L, S, lsb[0], nod[0], lj[0], tag);
                    end

        // R5: length limits
        run_cfg(6'd40, 32, 32, 1'b0, 1'b0, 1'b0, "R5");
        run_cfg(6'd3, 12, 14, 1'b0, 1'b1, 1'b0, "R5");

        // R8: short left word is dropped, error is sticky, next word survives
        do_reset(6'd16, 16, 1'b0, 1'b0, 1'b0);
        cur_tag = "R8";
        send_slot(1'b1, 32'h0, 20, 1'b0, -1);
        send_slot(1'b0, 32'h0, 20, 1'b0, 3);
        send_slot(1'b1, 32'h0, 20, 1'b0, -1);
        send_slot(1'b0, 32'h0000_8001, 20, 1'b1, -1);
        send_slot(1'b1, 32'h0000_7FFE, 20, 1'b1, -1);
        check(frame_err === 1'b0, "R8", "error before short word", {31'd0, frame_err}, 32'd0);
        send_slot(1'b0, 32'h0000_ABCD, 10, 1'b0, -1);
        send_slot(1'b1, 32'h0000_1357, 20, 1'b1, -1);
        check(frame_err === 1'b1, "R8", "error after short word", {31'd0, frame_err}, 32'd1);
        send_slot(1'b0, 32'h0000_2468, 20, 1'b1, -1);
        send_slot(1'b1, 32'h0000_FFFF, 20, 1'b1, -1);
        repeat (2) @(negedge sclk);
        check(frame_err === 1'b1, "R8", "error stays set", {31'd0, frame_err}, 32'd1);
        check(exp_q.size() == 0, "R8", "pending words", 32'(exp_q.size()), 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule